// File: doc/BRIEF.md
# SCSI Automatic PIO Handshake Engine

This block moves one byte across a SCSI bus with a single REQ/ACK handshake each time the processor asks for one. The processor sets a start bit, and the engine then runs the handshake on its own. It drives ACK when it acts as initiator and REQ when it acts as target. When the byte has gone across, the start bit clears itself and a sticky command-done interrupt is raised. The processor paces the transfer byte by byte. Before an outbound byte it writes the byte into the data register. After an inbound byte it reads the latched byte back.

Each byte is checked against the phase the processor expects. If the observed bus phase differs, the engine drives neither REQ nor ACK and sets a sticky mismatch flag. It then waits until software clears the start bit and starts again. Clearing the start bit at any point aborts the handshake and releases the bus lines on the next clock. A read-path select lets the processor choose between the latched inbound byte and the live bus data lines. The live path is used for manual, processor-driven transfers.

Top module: `pio_hs_engine`

## Requirements
- R1: After reset, the start bit, REQ out, ACK out, data output enable, command-done and mismatch are all 0.
- R2: A start pulse sets the start bit on the next clock. One handshake follows. When it completes, the start bit returns to 0 and command-done becomes 1 in the same clock.
- R3: In the initiator role (role_tgt = 0) the engine waits in the first handshake cycle for REQ. It asserts ACK one clock after it samples REQ high with a matching phase. ACK stays high while REQ stays high and falls one clock after REQ is sampled low.
- R4: In the target role (role_tgt = 1) the engine raises REQ two clocks after the start pulse when the phase matches. It drops REQ one clock after it samples ACK high. It completes one clock after it samples ACK low, and REQ stays low meanwhile.
- R5: The inbound byte is captured from the bus data lines at the clock where ACK is first asserted (initiator) or ACK is first seen (target). Inbound means phase bit 0 is 1 for the initiator and 0 for the target. With auto_rd_sel = 1 the read port returns this byte even after the bus data change.
- R6: With auto_rd_sel = 0 the read port returns the live bus data lines without any latching.
- R7: A byte written to the data register is held on bus_data_out. bus_data_oe is 1 only while a handshake is active and the direction is outbound, meaning expected phase bit 0 equals role_tgt.
- R8: If the observed phase differs from the expected phase, neither REQ nor ACK is driven, mismatch is set, the start bit stays 1 and no command-done is raised. After software clears the start bit, a new start with a matching phase completes normally.
- R9: Clearing the start bit during a handshake releases REQ and ACK and clears the start bit on the next clock, and no command-done is raised.
- R10: Command-done and mismatch stay set until their own clear pulse. A new set in the same clock as a clear wins.
- R11: A start pulse while the start bit is already 1 has no effect, so no second handshake follows the completion. A start pulse together with a clear pulse leaves the start bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the data register |
| reg_wr_data | input | DATA_W | Outbound byte written to the data register |
| reg_rd_data | output | DATA_W | Read port: latched inbound byte or live bus data |
| auto_rd_sel | input | 1 | 1 selects the latched byte, 0 the live bus lines |
| start_set | input | 1 | Pulse that sets the start bit |
| start_clr | input | 1 | Pulse that clears the start bit (aborts) |
| start_busy | output | 1 | Current value of the start bit |
| exp_phase | input | PH_W | Expected phase; bit 0 is the data direction bit |
| role_tgt | input | 1 | 1 = target role, 0 = initiator role |
| done_clr | input | 1 | Clears command-done |
| mism_clr | input | 1 | Clears the mismatch flag |
| bus_phase_in | input | PH_W | Observed phase lines |
| bus_req_in | input | 1 | Observed REQ |
| bus_ack_in | input | 1 | Observed ACK |
| bus_req_out | output | 1 | REQ driven by the engine |
| bus_ack_out | output | 1 | ACK driven by the engine |
| bus_data_in | input | DATA_W | Observed data lines |
| bus_data_out | output | DATA_W | Data to drive onto the bus |
| bus_data_oe | output | 1 | Data output enable |
| cmd_done | output | 1 | Sticky command-done interrupt |
| phase_err | output | 1 | Sticky phase-mismatch flag |

## Verification
The properties take for granted that all bus inputs are already synchronous to clk. They also assume that role_tgt and exp_phase do not change while the start bit is set, because direction and role are decoded from those inputs in every cycle. The directed stimulus drives every input on the falling edge. It programs role and expected phase only while the engine is idle, and it moves REQ, ACK and the phase lines one step at a time, the way a well-behaved peer would.

// File: rtl/pio_hs_pkg.sv
package pio_hs_pkg;

    // Bit of the phase vector that carries the data direction.
    localparam int IO_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_I_WAIT = 3'd1,
        ST_I_ACK  = 3'd2,
        ST_T_REQ  = 3'd3,
        ST_T_REL  = 3'd4,
        ST_HALT   = 3'd5
    } hs_state_e;

    typedef struct packed {
        hs_state_e st;
        logic      start;
        logic      done;
        logic      mism;
    } hs_fsm_t;

endpackage

// File: rtl/pio_phase_cmp.sv
module pio_phase_cmp #(
    parameter int PH_W = 3
) (
    input  logic [PH_W-1:0] exp_ph,
    input  logic [PH_W-1:0] obs_ph,
    output logic            match
);
    logic [PH_W-1:0] diff;

    for (genvar i = 0; i < PH_W; i++) begin : g_bit
        assign diff[i] = exp_ph[i] ^ obs_ph[i];
    end

    assign match = ~|diff;
endmodule

// File: rtl/pio_hs_fsm.sv
module pio_hs_fsm
    import pio_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_set,
    input  logic start_clr,
    input  logic done_clr,
    input  logic mism_clr,
    input  logic role_tgt,
    input  logic phase_ok,
    input  logic req_in,
    input  logic ack_in,
    output logic start_q,
    output logic done_q,
    output logic mism_q,
    output logic req_out,
    output logic ack_out,
    output logic busy,
    output logic cap
);
    hs_fsm_t r_q, r_d;
    logic    done_set, mism_set;

    always_comb begin
        r_d      = r_q;
        done_set = 1'b0;
        mism_set = 1'b0;
        cap      = 1'b0;
        if (start_set) r_d.start = 1'b1;
        case (r_q.st)
            ST_IDLE: begin
                if (r_q.start) begin
                    if (!role_tgt)     r_d.st = ST_I_WAIT;
                    else if (phase_ok) r_d.st = ST_T_REQ;
                    else begin
                        r_d.st   = ST_HALT;
                        mism_set = 1'b1;
                    end
                end
            end
            ST_I_WAIT: begin
                if (req_in) begin
                    if (phase_ok) begin
                        r_d.st = ST_I_ACK;
                        cap    = 1'b1;
                    end else begin
                        r_d.st   = ST_HALT;
                        mism_set = 1'b1;
                    end
                end
            end
            ST_I_ACK: begin
                if (!req_in) begin
                    r_d.st    = ST_IDLE;
                    r_d.start = 1'b0;
                    done_set  = 1'b1;
                end
            end
            ST_T_REQ: begin
                if (ack_in) begin
                    r_d.st = ST_T_REL;
                    cap    = 1'b1;
                end
            end
            ST_T_REL: begin
                if (!ack_in) begin
                    r_d.st    = ST_IDLE;
                    r_d.start = 1'b0;
                    done_set  = 1'b1;
                end
            end
            ST_HALT: begin
                if (!r_q.start) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (start_clr) begin
            r_d.st    = ST_IDLE;
            r_d.start = 1'b0;
            done_set  = 1'b0;
            cap       = 1'b0;
        end
        r_d.done = done_set | (r_q.done & ~done_clr);
        r_d.mism = mism_set | (r_q.mism & ~mism_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, start: 1'b0, done: 1'b0, mism: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign start_q = r_q.start;
    assign done_q  = r_q.done;
    assign mism_q  = r_q.mism;
    assign ack_out = (r_q.st == ST_I_ACK);
    assign req_out = (r_q.st == ST_T_REQ);
    assign busy    = (r_q.st == ST_I_WAIT) || (r_q.st == ST_I_ACK) ||
                     (r_q.st == ST_T_REQ)  || (r_q.st == ST_T_REL);
endmodule

// File: rtl/pio_data_path.sv
module pio_data_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              auto_sel,
    input  logic              dir_io,
    input  logic              role_tgt,
    input  logic              busy,
    input  logic              cap,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } dp_t;

    dp_t  r_q, r_d;
    logic outbound;

    assign outbound = (role_tgt == dir_io);

    always_comb begin
        r_d = r_q;
        if (wr_en)              r_d.tx = wr_data;
        if (cap && !outbound)   r_d.rx = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = auto_sel ? r_q.rx : bus_in;
    assign bus_out = r_q.tx;
    assign bus_oe  = busy & outbound;
endmodule

// File: rtl/pio_hs_engine.sv
module pio_hs_engine
    import pio_hs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              auto_rd_sel,
    input  logic              start_set,
    input  logic              start_clr,
    output logic              start_busy,
    input  logic [PH_W-1:0]   exp_phase,
    input  logic              role_tgt,
    input  logic              done_clr,
    input  logic              mism_clr,
    input  logic [PH_W-1:0]   bus_phase_in,
    input  logic              bus_req_in,
    input  logic              bus_ack_in,
    output logic              bus_req_out,
    output logic              bus_ack_out,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic              cmd_done,
    output logic              phase_err
);
    logic phase_ok, busy, cap;

    pio_phase_cmp #(.PH_W(PH_W)) u_cmp (
        .exp_ph (exp_phase),
        .obs_ph (bus_phase_in),
        .match  (phase_ok)
    );

    pio_hs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_set (start_set),
        .start_clr (start_clr),
        .done_clr  (done_clr),
        .mism_clr  (mism_clr),
        .role_tgt  (role_tgt),
        .phase_ok  (phase_ok),
        .req_in    (bus_req_in),
        .ack_in    (bus_ack_in),
        .start_q   (start_busy),
        .done_q    (cmd_done),
        .mism_q    (phase_err),
        .req_out   (bus_req_out),
        .ack_out   (bus_ack_out),
        .busy      (busy),
        .cap       (cap)
    );

    pio_data_path #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .auto_sel (auto_rd_sel),
        .dir_io   (exp_phase[IO_BIT]),
        .role_tgt (role_tgt),
        .busy     (busy),
        .cap      (cap),
        .bus_in   (bus_data_in),
        .rd_data  (reg_rd_data),
        .bus_out  (bus_data_out),
        .bus_oe   (bus_data_oe)
    );
endmodule

// File: rtl/pio_hs_engine_chk.sv
module pio_hs_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start_clr,
    input logic start_busy,
    input logic role_tgt,
    input logic mism_clr,
    input logic bus_req_in,
    input logic bus_ack_in,
    input logic bus_req_out,
    input logic bus_ack_out,
    input logic bus_data_oe,
    input logic cmd_done,
    input logic phase_err
);
    p_ack_initiator_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_out |-> !role_tgt);

    p_ack_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack_out && bus_req_in && !start_clr) |=> bus_ack_out);

    p_req_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_out |-> role_tgt);

    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_out && !bus_ack_in && !start_clr) |=> bus_req_out);

    p_done_ends_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_done) |-> !start_busy);

    p_oe_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> start_busy);

    p_mism_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_err) |-> (!bus_req_out && !bus_ack_out && start_busy));

    p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> (!bus_req_out && !bus_ack_out && !start_busy));

    p_mism_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_err && !mism_clr) |=> phase_err);
endmodule

bind pio_hs_engine pio_hs_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_clr   (start_clr),
    .start_busy  (start_busy),
    .role_tgt    (role_tgt),
    .mism_clr    (mism_clr),
    .bus_req_in  (bus_req_in),
    .bus_ack_in  (bus_ack_in),
    .bus_req_out (bus_req_out),
    .bus_ack_out (bus_ack_out),
    .bus_data_oe (bus_data_oe),
    .cmd_done    (cmd_done),
    .phase_err   (phase_err)
);

// File: tb/pio_hs_engine_bench.sv
module pio_hs_engine_bench;
    localparam int DW = 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [DW-1:0] reg_wr_data = '0;
    logic [DW-1:0] reg_rd_data;
    logic          auto_rd_sel = 1'b1;
    logic          start_set = 1'b0;
    logic          start_clr = 1'b0;
    logic          start_busy;
    logic [PW-1:0] exp_phase = '0;
    logic          role_tgt = 1'b0;
    logic          done_clr = 1'b0;
    logic          mism_clr = 1'b0;
    logic [PW-1:0] bus_phase_in = '0;
    logic          bus_req_in = 1'b0;
    logic          bus_ack_in = 1'b0;
    logic          bus_req_out;
    logic          bus_ack_out;
    logic [DW-1:0] bus_data_in = '0;
    logic [DW-1:0] bus_data_out;
    logic          bus_data_oe;
    logic          cmd_done;
    logic          phase_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pio_hs_engine u_pio_hs_engine (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_set = 1'b1; nedge(); start_set = 1'b0;
    endtask

    task automatic clear_done();
        done_clr = 1'b1; nedge(); done_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) nedge();
        rst_n = 1'b1;
        nedge();
        check("R1 start", start_busy, 0);
        check("R1 ack", bus_ack_out, 0);
        check("R1 req", bus_req_out, 0);
        check("R1 oe", bus_data_oe, 0);
        check("R1 done", cmd_done, 0);
        check("R1 mism", phase_err, 0);
    endtask

    task automatic t_init_in();
        role_tgt = 0; exp_phase = 3'b001; bus_phase_in = 3'b001; auto_rd_sel = 1;
        pulse_start();
        check("R2 start set", start_busy, 1);
        check("R3 no ack before req", bus_ack_out, 0);
        nedge();
        check("R3 wait req", bus_ack_out, 0);
        check("R7 oe inbound", bus_data_oe, 0);
        bus_data_in = 8'hA5; bus_req_in = 1;
        nedge();
        check("R3 ack up", bus_ack_out, 1);
        bus_data_in = 8'h00;
        nedge();
        check("R3 ack held", bus_ack_out, 1);
        check("R2 no early done", cmd_done, 0);
        bus_req_in = 0;
        nedge();
        check("R3 ack released", bus_ack_out, 0);
        check("R2 start cleared", start_busy, 0);
        check("R2 done", cmd_done, 1);
        check("R5 latched byte", reg_rd_data, 8'hA5);
        bus_req_in = 1;
        nedge(); nedge();
        check("R11 single handshake", bus_ack_out, 0);
        bus_req_in = 0;
        clear_done();
        check("R10 done cleared", cmd_done, 0);
    endtask

    task automatic t_tgt_in();
        role_tgt = 1; exp_phase = 3'b001; bus_phase_in = 3'b001;
        reg_wr_en = 1; reg_wr_data = 8'h3C; nedge(); reg_wr_en = 0;
        pulse_start();
        check("R4 start", start_busy, 1);
        check("R4 req not yet", bus_req_out, 0);
        nedge();
        check("R4 req up", bus_req_out, 1);
        check("R7 oe target out", bus_data_oe, 1);
        check("R7 data held", bus_data_out, 8'h3C);
        bus_ack_in = 1;
        nedge();
        check("R4 req dropped", bus_req_out, 0);
        check("R4 not done", cmd_done, 0);
        nedge();
        check("R4 req stays low", bus_req_out, 0);
        check("R4 start held", start_busy, 1);
        bus_ack_in = 0;
        nedge();
        check("R4 done", cmd_done, 1);
        check("R4 start cleared", start_busy, 0);
        check("R7 oe off idle", bus_data_oe, 0);
        clear_done();
    endtask

    task automatic t_init_out();
        role_tgt = 0; exp_phase = 3'b000; bus_phase_in = 3'b000;
        reg_wr_en = 1; reg_wr_data = 8'h96; nedge(); reg_wr_en = 0;
        pulse_start();
        nedge();
        check("R7 oe init out", bus_data_oe, 1);
        check("R7 data out", bus_data_out, 8'h96);
        bus_req_in = 1; start_set = 1;
        nedge();
        start_set = 0;
        check("R3 ack out phase", bus_ack_out, 1);
        bus_req_in = 0;
        nedge();
        check("R11 start clears despite set", start_busy, 0);
        check("R2 done out", cmd_done, 1);
        check("R7 oe off", bus_data_oe, 0);
        clear_done();
        start_set = 1; start_clr = 1;
        nedge();
        start_set = 0; start_clr = 0;
        check("R11 clear wins", start_busy, 0);
        nedge();
        check("R11 still idle", bus_ack_out, 0);
    endtask

    task automatic t_mismatch();
        role_tgt = 0; exp_phase = 3'b001; bus_phase_in = 3'b011; bus_req_in = 1;
        pulse_start();
        check("R8 start", start_busy, 1);
        nedge();
        check("R8 no ack", bus_ack_out, 0);
        nedge();
        check("R8 mism set", phase_err, 1);
        check("R8 no ack halt", bus_ack_out, 0);
        check("R8 start stays", start_busy, 1);
        nedge();
        check("R8 no done", cmd_done, 0);
        start_clr = 1; nedge(); start_clr = 0;
        check("R8 start cleared", start_busy, 0);
        bus_phase_in = 3'b001;
        pulse_start();
        nedge(); nedge();
        check("R8 retry ack", bus_ack_out, 1);
        check("R10 mism sticky", phase_err, 1);
        bus_req_in = 0; done_clr = 1;
        nedge();
        done_clr = 0;
        check("R10 set wins", cmd_done, 1);
        clear_done();
        check("R10 done clr", cmd_done, 0);
        mism_clr = 1; nedge(); mism_clr = 0;
        check("R10 mism clr", phase_err, 0);
    endtask

    task automatic t_abort();
        role_tgt = 0; exp_phase = 3'b001; bus_phase_in = 3'b001;
        pulse_start();
        bus_req_in = 1;
        nedge();
        nedge();
        check("R9 ack before abort", bus_ack_out, 1);
        start_clr = 1; nedge(); start_clr = 0;
        check("R9 ack released", bus_ack_out, 0);
        check("R9 start cleared", start_busy, 0);
        nedge();
        check("R9 no done init", cmd_done, 0);
        bus_req_in = 0;
        role_tgt = 1;
        pulse_start();
        nedge();
        check("R9 req before abort", bus_req_out, 1);
        start_clr = 1; nedge(); start_clr = 0;
        check("R9 req released", bus_req_out, 0);
        nedge();
        check("R9 no done tgt", cmd_done, 0);
        role_tgt = 0;
    endtask

    task automatic t_manual();
        auto_rd_sel = 0; bus_data_in = 8'h5A;
        nedge();
        check("R6 live read", reg_rd_data, 8'h5A);
        bus_data_in = 8'hC3;
        nedge();
        check("R6 live follows", reg_rd_data, 8'hC3);
        auto_rd_sel = 1;
    endtask

    initial begin
        t_reset();
        t_init_in();
        t_tgt_in();
        t_init_out();
        t_mismatch();
        t_abort();
        t_manual();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule